// File: doc/BRIEF.md
# RAW Hazard Stall Controller

This block decides, every cycle, whether the decode stage of a five-stage in-order pipeline may advance. It compares the two source register numbers of the instruction in decode (stage 2) with the destination register numbers of the three older instructions in stages 3, 4 and 5. A match counts only when the older instruction belongs to a class that writes the register file. A true read-after-write dependence freezes fetch and decode and replaces the instruction entering stage 3 with a nop. The older instructions keep moving while the freeze holds. Each cycle the dependence advances one stage, first to the stage 4 pair and then to the stage 5 pair, and the freeze ends once no pair needs it. Write-after-write and write-after-read cases need no logic, because every register write happens in stage 5 in issue order.

A build-time parameter selects the policy. Without forwarding, any register-writing producer in stages 3 to 5 stalls a dependent decode instruction. With forwarding, a result reaches the execute inputs directly, so only cases that forwarding cannot cover stall. These cases are a load directly ahead of its consumer, and branches that need their operands already in decode. The decision logic is combinational. A single flop holds the outputs low from reset until the first clock edge after reset is released.

Top module: `hz_stall_ctrl`

## Requirements
- R1: Operation classes use a 3-bit code: 0 nop, 1 ALU, 2 load, 3 load-address, 4 branch-and-link, 5 store, 6 branch, 7 halt. Only codes 1 to 4 write a register and can cause a hazard as producers.
- R2: Without forwarding, a stall is raised when stage 3, 4 or 5 holds a writing class whose destination equals the stage-2 first source.
- R3: The stage-2 second source is compared in the same way only when the stage-2 immediate flag is 0. When the flag is 1, a match on the second source is ignored.
- R4: A nop (code 0) in stage 2 never causes a stall.
- R5: The freeze of stage 1, the freeze of stage 2 and the stage-3 nop request are always raised and dropped together.
- R6: While reset is low, and until the first rising clock edge after it goes high, all three outputs are 0.
- R7: Without forwarding, an ALU consumer directly behind an ALU producer stalls for exactly 3 cycles while the producer drains. With forwarding, a consumer directly behind a load stalls for exactly 1 cycle.
- R8: With forwarding, a producer of class ALU, load-address or branch-and-link causes no stall for a consumer that is not a branch (code 4 or 6). A load that is already in stage 4 or 5 also causes no stall for such a consumer.
- R9: With forwarding, a load in stage 3 whose destination matches a stage-2 source causes a stall.
- R10: With forwarding, a stage-2 consumer of code 4 or 6 stalls on any matching writer in stage 3 and on a matching load in stage 4. It does not stall on a matching ALU result in stage 4.
- R11: Register number 0 is compared like every other register number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| s2_cls_i | input | 3 | Class code of the decode-stage instruction |
| s2_rb_i | input | REG_W | First source register of the decode instruction |
| s2_rc_i | input | REG_W | Second source register of the decode instruction |
| s2_imm_i | input | 1 | Decode instruction uses an immediate instead of the second source |
| s3_cls_i | input | 3 | Class code in stage 3 |
| s3_ra_i | input | REG_W | Destination register in stage 3 |
| s4_cls_i | input | 3 | Class code in stage 4 |
| s4_ra_i | input | REG_W | Destination register in stage 4 |
| s5_cls_i | input | 3 | Class code in stage 5 |
| s5_ra_i | input | REG_W | Destination register in stage 5 |
| pause1_o | output | 1 | Hold the fetch-stage output registers |
| pause2_o | output | 1 | Hold the decode-stage output registers |
| bubble3_o | output | 1 | Force the class entering stage 3 to nop |

## Verification
The bound checker tests these properties on every cycle:
- The three outputs move together, and they stay quiet in reset.
- Non-writing classes and a decode-stage nop never stall.
- The immediate flag masks the second source.
- Each mode's mandatory stall cases always stall.
- In forwarding mode, non-branch consumers stall only behind a load.

Only the directed scenarios can show the time-based behaviour. A dependence must be followed through stages 4 and 5 as the pipeline drains, giving exactly 3 stall cycles without forwarding and 1 with it. The scenarios also cover the class-by-class producer decode and the stage-4 cases for branch consumers.

// File: rtl/hz_pkg.sv
package hz_pkg;

   typedef enum logic [2:0] {
      CLS_NOP    = 3'd0,
      CLS_ALU    = 3'd1,
      CLS_LOAD   = 3'd2,
      CLS_LADR   = 3'd3,
      CLS_BRL    = 3'd4,
      CLS_STORE  = 3'd5,
      CLS_BRANCH = 3'd6,
      CLS_HALT   = 3'd7
   } op_cls_e;

   localparam int CLS_W       = 3;
   localparam int LATE_STAGES = 3;   // stages 3, 4 and 5

   // classes whose result lands in the register file in stage 5
   function automatic logic writes_reg(op_cls_e c);
      return (c == CLS_ALU) || (c == CLS_LOAD) || (c == CLS_LADR) || (c == CLS_BRL);
   endfunction

   // consumers that need their operands already in decode
   function automatic logic reads_in_decode(op_cls_e c);
      return (c == CLS_BRANCH) || (c == CLS_BRL);
   endfunction

endpackage

// File: rtl/hz_pair_match.sv
module hz_pair_match
   import hz_pkg::*;
#(
   parameter int REG_W = 5
) (
   input  op_cls_e          prod_cls_i,
   input  logic [REG_W-1:0] prod_ra_i,
   input  op_cls_e          cons_cls_i,
   input  logic [REG_W-1:0] cons_rb_i,
   input  logic [REG_W-1:0] cons_rc_i,
   input  logic             cons_imm_i,
   output logic             hit_o
);

   logic rb_eq;
   logic rc_eq;

   always_comb begin
      rb_eq = (prod_ra_i == cons_rb_i);
      rc_eq = (prod_ra_i == cons_rc_i) && !cons_imm_i;
      hit_o = writes_reg(prod_cls_i) && (cons_cls_i != CLS_NOP) && (rb_eq || rc_eq);
   end

endmodule

// File: rtl/hz_stall_merge.sv
module hz_stall_merge
   import hz_pkg::*;
#(
   parameter bit FORWARD = 1'b0
) (
   input  logic [LATE_STAGES-1:0] hit_i,     // bit 0 = stage 3
   input  op_cls_e                cons_cls_i,
   input  op_cls_e                s3_cls_i,
   input  op_cls_e                s4_cls_i,
   output logic                   stall_o
);

   logic plain_stall;
   logic fwd_stall;
   logic early_use;

   always_comb begin
      early_use   = reads_in_decode(cons_cls_i);
      plain_stall = |hit_i;
      fwd_stall   = (hit_i[0] && ((s3_cls_i == CLS_LOAD) || early_use))
                 || (hit_i[1] && (s4_cls_i == CLS_LOAD) && early_use);
      stall_o     = FORWARD ? fwd_stall : plain_stall;
   end

endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
   import hz_pkg::*;
#(
   parameter int REG_W   = 5,
   parameter bit FORWARD = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [2:0]       s2_cls_i,
   input  logic [REG_W-1:0] s2_rb_i,
   input  logic [REG_W-1:0] s2_rc_i,
   input  logic             s2_imm_i,
   input  logic [2:0]       s3_cls_i,
   input  logic [REG_W-1:0] s3_ra_i,
   input  logic [2:0]       s4_cls_i,
   input  logic [REG_W-1:0] s4_ra_i,
   input  logic [2:0]       s5_cls_i,
   input  logic [REG_W-1:0] s5_ra_i,
   output logic             pause1_o,
   output logic             pause2_o,
   output logic             bubble3_o
);

   generate
      if (REG_W < 1 || REG_W > 8) begin : g_bad_reg_w
         $error("hz_stall_ctrl: REG_W must lie in 1..8");
      end
   endgenerate

   op_cls_e                prod_cls [LATE_STAGES];
   logic [REG_W-1:0]       prod_ra  [LATE_STAGES];
   logic [LATE_STAGES-1:0] hit;
   logic                   stall;
   logic                   run_q;
   op_cls_e                cons_cls;

   assign cons_cls    = op_cls_e'(s2_cls_i);
   assign prod_cls[0] = op_cls_e'(s3_cls_i);
   assign prod_cls[1] = op_cls_e'(s4_cls_i);
   assign prod_cls[2] = op_cls_e'(s5_cls_i);
   assign prod_ra[0]  = s3_ra_i;
   assign prod_ra[1]  = s4_ra_i;
   assign prod_ra[2]  = s5_ra_i;

   genvar k;
   generate
      for (k = 0; k < LATE_STAGES; k++) begin : g_pair
         hz_pair_match #(.REG_W(REG_W)) u_match (
            .prod_cls_i (prod_cls[k]),
            .prod_ra_i  (prod_ra[k]),
            .cons_cls_i (cons_cls),
            .cons_rb_i  (s2_rb_i),
            .cons_rc_i  (s2_rc_i),
            .cons_imm_i (s2_imm_i),
            .hit_o      (hit[k])
         );
      end
   endgenerate

   hz_stall_merge #(.FORWARD(FORWARD)) u_merge (
      .hit_i      (hit),
      .cons_cls_i (cons_cls),
      .s3_cls_i   (prod_cls[0]),
      .s4_cls_i   (prod_cls[1]),
      .stall_o    (stall)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) run_q <= 1'b0;
      else         run_q <= 1'b1;
   end

   always_comb begin
      pause1_o  = run_q && stall;
      pause2_o  = run_q && stall;
      bubble3_o = run_q && stall;
   end

endmodule

// File: rtl/hz_stall_ctrl_chk.sv
module hz_stall_ctrl_chk #(
   parameter int REG_W   = 5,
   parameter bit FORWARD = 1'b0
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [2:0]       s2_cls_i,
   input logic [REG_W-1:0] s2_rb_i,
   input logic [REG_W-1:0] s2_rc_i,
   input logic             s2_imm_i,
   input logic [2:0]       s3_cls_i,
   input logic [REG_W-1:0] s3_ra_i,
   input logic [2:0]       s4_cls_i,
   input logic [REG_W-1:0] s4_ra_i,
   input logic [2:0]       s5_cls_i,
   input logic [REG_W-1:0] s5_ra_i,
   input logic             pause1_o,
   input logic             pause2_o,
   input logic             bubble3_o
);

   logic w3, w4, w5, rb_any, s2_branch, any_load;

   always_comb begin
      w3        = (s3_cls_i >= 3'd1) && (s3_cls_i <= 3'd4);
      w4        = (s4_cls_i >= 3'd1) && (s4_cls_i <= 3'd4);
      w5        = (s5_cls_i >= 3'd1) && (s5_cls_i <= 3'd4);
      rb_any    = (w3 && s3_ra_i == s2_rb_i) || (w4 && s4_ra_i == s2_rb_i)
               || (w5 && s5_ra_i == s2_rb_i);
      s2_branch = (s2_cls_i == 3'd4) || (s2_cls_i == 3'd6);
      any_load  = (s3_cls_i == 3'd2) || (s4_cls_i == 3'd2) || (s5_cls_i == 3'd2);
   end

   AST_RESET_QUIET: assert property (@(posedge clk_i)
      !rst_ni |-> !(pause1_o || pause2_o || bubble3_o)); // R6

   AST_OUTPUTS_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pause1_o || pause2_o || bubble3_o) |-> (pause1_o && pause2_o && bubble3_o)); // R5

   AST_NOP_CONSUMER_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s2_cls_i == 3'd0) |-> !pause1_o); // R4

   AST_NON_WRITERS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!w3 && !w4 && !w5) |-> !pause2_o); // R1

   AST_IMM_MASKS_RC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s2_imm_i && !rb_any) |-> !bubble3_o); // R3

   generate
      if (!FORWARD) begin : g_plain
         AST_PLAIN_MATCH_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (s2_cls_i != 3'd0 && w3 && s3_ra_i == s2_rb_i && $past(rst_ni)) |-> pause1_o); // R2
      end else begin : g_fwd
         AST_FWD_ALU_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!s2_branch && !any_load) |-> !pause1_o); // R8
         AST_FWD_LOAD_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (s2_cls_i != 3'd0 && s3_cls_i == 3'd2 && s3_ra_i == s2_rb_i && $past(rst_ni))
            |-> pause1_o); // R9
         AST_FWD_BRANCH_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (s2_branch && w3 && s3_ra_i == s2_rb_i && $past(rst_ni)) |-> pause1_o); // R10
      end
   endgenerate

endmodule

bind hz_stall_ctrl hz_stall_ctrl_chk #(.REG_W(REG_W), .FORWARD(FORWARD)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .s2_cls_i  (s2_cls_i),
   .s2_rb_i   (s2_rb_i),
   .s2_rc_i   (s2_rc_i),
   .s2_imm_i  (s2_imm_i),
   .s3_cls_i  (s3_cls_i),
   .s3_ra_i   (s3_ra_i),
   .s4_cls_i  (s4_cls_i),
   .s4_ra_i   (s4_ra_i),
   .s5_cls_i  (s5_cls_i),
   .s5_ra_i   (s5_ra_i),
   .pause1_o  (pause1_o),
   .pause2_o  (pause2_o),
   .bubble3_o (bubble3_o)
);

// File: tb/test_hz_stall_ctrl.sv
module test_hz_stall_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int REG_W      = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [2:0]       s2_cls = '0, s3_cls = '0, s4_cls = '0, s5_cls = '0;
   logic [REG_W-1:0] s2_rb = '0, s2_rc = '0, s3_ra = '0, s4_ra = '0, s5_ra = '0;
   logic             s2_imm = 1'b0;
   logic             p1_n, p2_n, b3_n, p1_f, p2_f, b3_f;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hz_stall_ctrl #(.REG_W(REG_W), .FORWARD(1'b0)) i_hz_stall_ctrl (
      .clk_i(clk), .rst_ni(rst_n),
      .s2_cls_i(s2_cls), .s2_rb_i(s2_rb), .s2_rc_i(s2_rc), .s2_imm_i(s2_imm),
      .s3_cls_i(s3_cls), .s3_ra_i(s3_ra), .s4_cls_i(s4_cls), .s4_ra_i(s4_ra),
      .s5_cls_i(s5_cls), .s5_ra_i(s5_ra),
      .pause1_o(p1_n), .pause2_o(p2_n), .bubble3_o(b3_n));

   hz_stall_ctrl #(.REG_W(REG_W), .FORWARD(1'b1)) i_hz_stall_ctrl_fwd (
      .clk_i(clk), .rst_ni(rst_n),
      .s2_cls_i(s2_cls), .s2_rb_i(s2_rb), .s2_rc_i(s2_rc), .s2_imm_i(s2_imm),
      .s3_cls_i(s3_cls), .s3_ra_i(s3_ra), .s4_cls_i(s4_cls), .s4_ra_i(s4_ra),
      .s5_cls_i(s5_cls), .s5_ra_i(s5_ra),
      .pause1_o(p1_f), .pause2_o(p2_f), .bubble3_o(b3_f));

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         checks++; fails++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
         summary();
      end
   end

   task automatic check(string req, logic [2:0] act, logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // apply one set of stage contents away from the clock edge
   task automatic apply(logic [2:0] c2, logic [4:0] rb, logic [4:0] rc, logic imm,
                        logic [2:0] c3, logic [4:0] ra3, logic [2:0] c4, logic [4:0] ra4,
                        logic [2:0] c5, logic [4:0] ra5);
      @(negedge clk);
      s2_cls = c2; s2_rb = rb; s2_rc = rc; s2_imm = imm;
      s3_cls = c3; s3_ra = ra3; s4_cls = c4; s4_ra = ra4; s5_cls = c5; s5_ra = ra5;
      #1;
   endtask

   task automatic t_reset();
      apply(3'd1, 5'd7, 5'd0, 1'b0, 3'd1, 5'd7, 3'd0, 5'd0, 3'd0, 5'd0);
      check("R6 plain in reset", {p1_n, p2_n, b3_n}, 3'b000);
      check("R6 fwd in reset",   {p1_f, p2_f, b3_f}, 3'b000);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); #1;
   endtask

   task automatic t_classes();
      for (int c = 0; c < 8; c++) begin
         apply(3'd1, 5'd9, 5'd1, 1'b0, 3'(c), 5'd9, 3'd0, 5'd0, 3'd0, 5'd0);
         check($sformatf("R1 R5 producer class %0d", c), {p1_n, p2_n, b3_n},
               (c >= 1 && c <= 4) ? 3'b111 : 3'b000);
      end
   endtask

   task automatic t_plain();
      apply(3'd1, 5'd12, 5'd1, 1'b0, 3'd0, 5'd0, 3'd1, 5'd12, 3'd0, 5'd0);
      check("R2 stage4 ALU match", {p1_n, p2_n, b3_n}, 3'b111);
      apply(3'd5, 5'd3, 5'd1, 1'b0, 3'd0, 5'd0, 3'd0, 5'd0, 3'd3, 5'd3);
      check("R2 stage5 ladr match", {p1_n, p2_n, b3_n}, 3'b111);
      apply(3'd1, 5'd3, 5'd4, 1'b0, 3'd1, 5'd5, 3'd2, 5'd6, 3'd1, 5'd8);
      check("R2 no match", {p1_n, p2_n, b3_n}, 3'b000);
      apply(3'd1, 5'd3, 5'd20, 1'b0, 3'd0, 5'd0, 3'd2, 5'd20, 3'd0, 5'd0);
      check("R3 rc match no imm", {p1_n, p2_n, b3_n}, 3'b111);
      apply(3'd1, 5'd3, 5'd20, 1'b1, 3'd0, 5'd0, 3'd2, 5'd20, 3'd0, 5'd0);
      check("R3 rc match with imm", {p1_n, p2_n, b3_n}, 3'b000);
      apply(3'd0, 5'd6, 5'd6, 1'b0, 3'd1, 5'd6, 3'd2, 5'd6, 3'd1, 5'd6);
      check("R4 nop consumer plain", {p1_n, p2_n, b3_n}, 3'b000);
      check("R4 nop consumer fwd",   {p1_f, p2_f, b3_f}, 3'b000);
      apply(3'd1, 5'd0, 5'd1, 1'b1, 3'd1, 5'd0, 3'd0, 5'd0, 3'd0, 5'd0);
      check("R11 r0 compared", {p1_n, p2_n, b3_n}, 3'b111);
   endtask

   task automatic t_forward();
      apply(3'd1, 5'd7, 5'd1, 1'b0, 3'd1, 5'd7, 3'd0, 5'd0, 3'd0, 5'd0);
      check("R8 fwd alu->alu", {p1_f, p2_f, b3_f}, 3'b000);
      apply(3'd5, 5'd7, 5'd1, 1'b0, 3'd0, 5'd0, 3'd2, 5'd7, 3'd0, 5'd0);
      check("R8 fwd load in stage4", {p1_f, p2_f, b3_f}, 3'b000);
      apply(3'd1, 5'd2, 5'd7, 1'b0, 3'd2, 5'd7, 3'd0, 5'd0, 3'd0, 5'd0);
      check("R9 fwd load adjacent", {p1_f, p2_f, b3_f}, 3'b111);
      apply(3'd6, 5'd7, 5'd1, 1'b0, 3'd1, 5'd7, 3'd0, 5'd0, 3'd0, 5'd0);
      check("R10 branch after alu", {p1_f, p2_f, b3_f}, 3'b111);
      apply(3'd4, 5'd7, 5'd1, 1'b0, 3'd0, 5'd0, 3'd2, 5'd7, 3'd0, 5'd0);
      check("R10 brl after load in stage4", {p1_f, p2_f, b3_f}, 3'b111);
      apply(3'd6, 5'd7, 5'd1, 1'b0, 3'd0, 5'd0, 3'd1, 5'd7, 3'd0, 5'd0);
      check("R10 branch alu in stage4", {p1_f, p2_f, b3_f}, 3'b000);
   endtask

   // pipeline model: on a stall the older stages advance and stage 3 gets a nop
   task automatic t_drain(logic fwd, logic [2:0] prod, int exp_stalls, string req);
      int stalls = 0;
      apply(3'd1, 5'd7, 5'd2, 1'b0, prod, 5'd7, 3'd0, 5'd0, 3'd0, 5'd0);
      for (int i = 0; i < 6; i++) begin
         if (!(fwd ? p1_f : p1_n)) break;
         stalls++;
         apply(s2_cls, s2_rb, s2_rc, s2_imm, 3'd0, 5'd0, s3_cls, s3_ra, s4_cls, s4_ra);
      end
      check(req, 3'(stalls), 3'(exp_stalls));
   endtask

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      t_classes();
      t_plain();
      t_forward();
      t_drain(1'b0, 3'd1, 3, "R7 plain alu drain stalls");
      t_drain(1'b1, 3'd2, 1, "R7 fwd load drain stalls");
      summary();
   end

endmodule